// File: doc/BRIEF.md
# Reloading Down-Counter Timer Bank

This block holds a set of identical timer channels. Each channel owns a 32-bit count that steps down by one on every tick of a clock divided from the system clock. When the count passes from zero to all ones, the channel loads a software-set constant instead, raises a sticky flag, and keeps counting down from the constant. An interrupt line per channel goes high while the flag is set and the channel's enable bit is on.

Software reaches every register over a 16-bit bus, one halfword per access. Reading the upper half of the count copies the whole live count into a holding register. The next lower-half read therefore returns a low half taken at the same instant as the upper half. Writes to the count use the same split: the upper half is staged first, and the lower-half write commits all 32 bits at once. All channels share one free-running prescaler, and each channel picks one of its taps.

Top module: `dtimer_bank`

## Requirements
- R1: After reset, the count and the constant of every channel are 0xFFFFFFFF, the control register reads 0, the holding register is 0, the prescaler count is 0 and every interrupt is low.
- R2: On each tick of its selected clock, a channel whose count is nonzero decrements the count by exactly one. Between ticks the count does not change.
- R3: The prescaler is a counter cleared by reset that increments every cycle. Select code k (0 to 4) divides by 4, 16, 64, 256 or 1024, and ticks in each cycle where the low 2(k+1) bits of the prescaler are all ones.
- R4: Select codes 5, 6 and 7 stop the channel, so its count holds its value.
- R5: On a tick with a count of zero, the count loads the constant value held before that edge, and the underflow flag is set.
- R6: Writing 0 to control bit 8 clears the underflow flag and writing 1 leaves it unchanged. An underflow in the same cycle as a clearing write wins, and the flag stays set.
- R7: The interrupt of each channel equals its underflow flag ANDed with control bit 5 (interrupt enable).
- R8: The control register holds the select code in bits 2:0, the enable in bit 5 and the flag in bit 8. All other bits read 0, and writes to them are ignored.
- R9: The halfword address is {channel, offset}, where offset is 3 bits: 0 control, 1 constant high, 2 constant low, 3 count high, 4 count low. Offsets 5 to 7 read 0 and ignore writes. Each constant half is written directly.
- R10: A read at offset 3 returns the live count bits 31:16 and, at that edge, copies all 32 count bits into the holding register. A read at offset 4 returns holding-register bits 15:0.
- R11: A write at offset 3 stages a halfword. A write at offset 4 loads {staged, written} into the count, and this load overrides any decrement or reload in the same cycle, with no underflow flagged.
- R12: Channels are independent: an access to one channel changes no state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one halfword per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | {channel, register offset} |
| bus_wdata | input | 16 | Write halfword |
| bus_rdata | output | 16 | Read halfword, combinational; 0 when idle |
| irq | output | 3 | Per-channel interrupt |

## Verification
The in-module assertions check on every cycle that a tick decrements by exactly one, that a zero count reloads the previous constant and sets the flag, that a stopped channel holds its count, that a lower-half write commits the staged value, that an upper-half read fills the holding register, and that the flag stays set until it is cleared. Only the bench's scenarios can show that the bus decode and the control-register layout match the map, that the tap cycles line up with a free-running prescaler, and that a split read returns one consistent count while the channel is counting. They also show that the channels do not disturb each other.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
   typedef enum logic [2:0] {
      RG_CTRL   = 3'd0,
      RG_CST_HI = 3'd1,
      RG_CST_LO = 3'd2,
      RG_CNT_HI = 3'd3,
      RG_CNT_LO = 3'd4
   } reg_e;

   localparam int OFS_W       = 3;
   localparam int SEL_W       = 3;
   localparam int CTL_IE_BIT  = 5;
   localparam int CTL_UNF_BIT = 8;
endpackage

// File: rtl/dtimer_prescale.sv
module dtimer_prescale #(
   parameter int NDIV = 5,
   parameter int STEP = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [NDIV-1:0] tick
);
   localparam int PS_W = STEP * NDIV;

   logic [PS_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   for (genvar k = 0; k < NDIV; k++) begin : g_tap
      assign tick[k] = &pre_q[STEP*(k+1)-1:0];
   end

   // R3: the prescaler wraps to zero after its all-ones value
   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (&pre_q) |=> (pre_q == '0));
endmodule

// File: rtl/dtimer_chan.sv
module dtimer_chan
   import dtimer_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int BUS_W = 16,
   parameter int NDIV  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NDIV-1:0]  tick_vec,
   input  logic             sel,
   input  logic             we,
   input  logic [OFS_W-1:0] ofs,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   output logic             irq
);
   logic [CNT_W-1:0] cnt_q, cst_q, hold_q;
   logic [BUS_W-1:0] stage_q;
   logic [SEL_W-1:0] psel_q;
   logic             ie_q, unf_q;
   logic             tick, rd_acc, wr_acc, commit, underflow;

   assign rd_acc = sel & ~we;
   assign wr_acc = sel & we;
   assign commit = wr_acc && (ofs == RG_CNT_LO);

   always_comb begin
      tick = 1'b0;
      for (int k = 0; k < NDIV; k++)
         if (psel_q == SEL_W'(k)) tick = tick_vec[k];
   end

   assign underflow = tick && (cnt_q == '0) && !commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '1;
      end else if (commit) begin
         cnt_q <= {stage_q, wdata};
      end else if (tick) begin
         cnt_q <= (cnt_q == '0) ? cst_q : cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cst_q   <= '1;
         stage_q <= '0;
         hold_q  <= '0;
      end else begin
         if (wr_acc && ofs == RG_CST_HI) cst_q[CNT_W-1:BUS_W] <= wdata;
         if (wr_acc && ofs == RG_CST_LO) cst_q[BUS_W-1:0]     <= wdata;
         if (wr_acc && ofs == RG_CNT_HI) stage_q              <= wdata;
         if (rd_acc && ofs == RG_CNT_HI) hold_q               <= cnt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psel_q <= '0;
         ie_q   <= 1'b0;
         unf_q  <= 1'b0;
      end else begin
         if (wr_acc && ofs == RG_CTRL) begin
            psel_q <= wdata[SEL_W-1:0];
            ie_q   <= wdata[CTL_IE_BIT];
         end
         if (underflow)
            unf_q <= 1'b1;
         else if (wr_acc && ofs == RG_CTRL && !wdata[CTL_UNF_BIT])
            unf_q <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_acc) begin
         case (ofs)
            RG_CTRL: begin
               rdata[SEL_W-1:0]   = psel_q;
               rdata[CTL_IE_BIT]  = ie_q;
               rdata[CTL_UNF_BIT] = unf_q;
            end
            RG_CST_HI: rdata = cst_q[CNT_W-1:BUS_W];
            RG_CST_LO: rdata = cst_q[BUS_W-1:0];
            RG_CNT_HI: rdata = cnt_q[CNT_W-1:BUS_W];
            RG_CNT_LO: rdata = hold_q[BUS_W-1:0];
            default:   rdata = '0;
         endcase
      end
   end

   assign irq = unf_q & ie_q;

   // R2: a tick on a nonzero count steps it down by one
   assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt_q != '0 && !commit) |=> (cnt_q == $past(cnt_q) - 1'b1));
   // R4: a reserved select code freezes the count
   assert_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (psel_q >= SEL_W'(NDIV) && !commit) |=> $stable(cnt_q));
   // R5: a zero count reloads the previous constant and flags
   assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt_q == '0 && !commit) |=> (cnt_q == $past(cst_q) && unf_q));
   // R6: the flag persists unless a clearing control write arrives
   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (unf_q && !(wr_acc && ofs == RG_CTRL)) |=> unf_q);
   // R10: an upper-half read captures the whole count
   assert_snap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && ofs == RG_CNT_HI) |=> (hold_q == $past(cnt_q)));
   // R11: the lower-half write loads the staged upper half
   assert_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (cnt_q == {$past(stage_q), $past(wdata)}));
endmodule

// File: rtl/dtimer_bank.sv
module dtimer_bank
   import dtimer_pkg::*;
#(
   parameter int NCH   = 3,
   parameter int CNT_W = 32,
   parameter int BUS_W = 16,
   parameter int NDIV  = 5,
   parameter int STEP  = 2,
   localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int AW   = CH_W + OFS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_en,
   input  logic             bus_we,
   input  logic [AW-1:0]    bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic [NCH-1:0]   irq
);
   if (CNT_W != 2 * BUS_W) begin : g_bad_width
      $error("count width must be twice the bus width");
   end
   if (BUS_W <= CTL_UNF_BIT) begin : g_bad_bus
      $error("bus too narrow for the control layout");
   end
   if (NDIV < 1 || NDIV >= (1 << SEL_W)) begin : g_bad_ndiv
      $error("NDIV must leave at least one reserved select code");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("at least one channel is required");
   end

   logic [NDIV-1:0]  tick_vec;
   logic [BUS_W-1:0] ch_rdata [NCH];
   logic [NCH-1:0]   ch_sel;

   dtimer_prescale #(.NDIV(NDIV), .STEP(STEP)) presc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_vec)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign ch_sel[i] = bus_en && (bus_addr[AW-1:OFS_W] == CH_W'(i));
      dtimer_chan #(.CNT_W(CNT_W), .BUS_W(BUS_W), .NDIV(NDIV)) chan_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick_vec (tick_vec),
         .sel      (ch_sel[i]),
         .we       (bus_we),
         .ofs      (bus_addr[OFS_W-1:0]),
         .wdata    (bus_wdata),
         .rdata    (ch_rdata[i]),
         .irq      (irq[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NCH; i++) bus_rdata = bus_rdata | ch_rdata[i];
   end

   // R9: at most one channel is selected per access
   assert_onesel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_sel));
endmodule

// File: tb/dtimer_bank_tb_top.sv
`timescale 1ns/1ps
module dtimer_bank_tb_top;
   localparam int NCH = 3;
   localparam int NV  = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        b_en = 1'b0, b_we = 1'b0;
   logic [4:0]  b_addr = '0;
   logic [15:0] b_wd = '0;
   logic [15:0] rdata;
   logic [2:0]  irq;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dtimer_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_en(b_en), .bus_we(b_we),
      .bus_addr(b_addr), .bus_wdata(b_wd), .bus_rdata(rdata), .irq(irq)
   );

   // reference state built from the requirements
   logic [31:0] m_cnt [NCH], m_cst [NCH], m_hold [NCH];
   logic [15:0] m_stage [NCH];
   logic [2:0]  m_psel [NCH];
   logic        m_ie [NCH], m_unf [NCH];
   logic [9:0]  m_pre;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pre = '0;
         for (int c = 0; c < NCH; c++) begin
            m_cnt[c] = '1; m_cst[c] = '1; m_hold[c] = '0; m_stage[c] = '0;
            m_psel[c] = '0; m_ie[c] = 1'b0; m_unf[c] = 1'b0;
         end
      end else begin
         for (int c = 0; c < NCH; c++) begin
            logic [9:0] mask;
            logic t, s, cm, uf;
            logic [2:0] rg;
            logic [31:0] ocst;
            rg   = b_addr[2:0];
            s    = b_en && (b_addr[4:3] == 2'(c));
            mask = (m_psel[c] < 3'd5) ? 10'((1 << (2 * (m_psel[c] + 1))) - 1) : '0;
            t    = (m_psel[c] < 3'd5) && ((m_pre & mask) == mask);
            cm   = s && b_we && rg == 3'd4;
            uf   = t && m_cnt[c] == 0 && !cm;
            ocst = m_cst[c];
            if (s && !b_we && rg == 3'd3) m_hold[c] = m_cnt[c];
            if (cm) m_cnt[c] = {m_stage[c], b_wd};
            else if (t) m_cnt[c] = (m_cnt[c] == 0) ? ocst : m_cnt[c] - 1;
            if (s && b_we) begin
               case (rg)
                  3'd0: begin
                     m_psel[c] = b_wd[2:0]; m_ie[c] = b_wd[5];
                     if (!b_wd[8]) m_unf[c] = 1'b0;
                  end
                  3'd1: m_cst[c][31:16] = b_wd;
                  3'd2: m_cst[c][15:0]  = b_wd;
                  3'd3: m_stage[c]      = b_wd;
                  default: ;
               endcase
            end
            if (uf) m_unf[c] = 1'b1;
         end
         m_pre = m_pre + 1;
      end
   end

   function automatic logic [15:0] exp_rd(int c, int rg);
      case (rg)
         0: return {7'b0, m_unf[c], 2'b0, m_ie[c], 2'b0, m_psel[c]};
         1: return m_cst[c][31:16];
         2: return m_cst[c][15:0];
         3: return m_cnt[c][31:16];
         4: return m_hold[c][15:0];
         default: return 16'h0;
      endcase
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic check_irq();
      logic [2:0] e;
      for (int c = 0; c < NCH; c++) e[c] = m_unf[c] & m_ie[c];
      check("R7 irq", 16'(irq), 16'(e));
   endtask

   // one access; a read is checked against the reference before the edge
   task automatic acc(logic w, int c, int rg, logic [15:0] d, string req);
      @(negedge clk);
      b_en = 1'b1; b_we = w; b_addr = 5'(c * 8 + rg); b_wd = d;
      #1;
      if (!w) check(req, rdata, exp_rd(c, rg));
      @(negedge clk);
      b_en = 1'b0; b_we = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // {we, chan[1:0], ofs[2:0], idle[3:0], data[15:0]}
   localparam logic [25:0] VEC [NV] = '{
      {1'b1, 2'd0, 3'd0, 4'd0, 16'h0027},   // R4 stop, enable
      {1'b1, 2'd0, 3'd3, 4'd0, 16'h1234},   // R11 stage
      {1'b1, 2'd0, 3'd4, 4'd0, 16'h5678},   // R11 commit
      {1'b0, 2'd0, 3'd3, 4'd0, 16'h0},      // R10
      {1'b0, 2'd0, 3'd4, 4'd0, 16'h0},      // R10
      {1'b1, 2'd0, 3'd1, 4'd0, 16'h0000},   // R9 const hi
      {1'b1, 2'd0, 3'd2, 4'd0, 16'h0009},   // R9 const lo
      {1'b0, 2'd0, 3'd2, 4'd0, 16'h0},
      {1'b1, 2'd0, 3'd3, 4'd0, 16'h0000},
      {1'b1, 2'd0, 3'd4, 4'd0, 16'h0002},
      {1'b1, 2'd0, 3'd0, 4'd15, 16'h0020},  // R5 run div4
      {1'b0, 2'd0, 3'd0, 4'd0, 16'h0},      // R6 flag up
      {1'b0, 2'd0, 3'd3, 4'd0, 16'h0},      // R5 reloaded
      {1'b0, 2'd0, 3'd4, 4'd0, 16'h0},
      {1'b1, 2'd0, 3'd0, 4'd0, 16'h0120},   // R6 write 1 keeps
      {1'b0, 2'd0, 3'd0, 4'd0, 16'h0},
      {1'b1, 2'd0, 3'd0, 4'd0, 16'h0027},   // R6 clear, stop
      {1'b0, 2'd0, 3'd0, 4'd0, 16'h0},
      {1'b1, 2'd1, 3'd0, 4'd15, 16'h0001},  // R3 div16
      {1'b0, 2'd1, 3'd3, 4'd0, 16'h0},
      {1'b0, 2'd1, 3'd4, 4'd0, 16'h0},
      {1'b1, 2'd2, 3'd0, 4'd15, 16'h0005},  // R4 reserved code
      {1'b0, 2'd2, 3'd3, 4'd0, 16'h0},
      {1'b0, 2'd2, 3'd4, 4'd0, 16'h0},
      {1'b1, 2'd0, 3'd7, 4'd0, 16'hFFFF},   // R9 hole ignored
      {1'b0, 2'd0, 3'd7, 4'd0, 16'h0},
      {1'b0, 2'd0, 3'd6, 4'd0, 16'h0},
      {1'b1, 2'd1, 3'd0, 4'd0, 16'hFEDA},   // R8 spare bits ignored
      {1'b0, 2'd1, 3'd0, 4'd0, 16'h0},
      {1'b0, 2'd0, 3'd3, 4'd0, 16'h0},      // R12 ch0 untouched
      {1'b0, 2'd0, 3'd4, 4'd0, 16'h0},
      {1'b0, 2'd2, 3'd1, 4'd0, 16'h0}
   };

   initial begin
      #1000000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      idle(2);
      rst_n = 1'b1;
      // R1 reset state
      acc(1'b0, 0, 0, 16'h0, "R1 ctrl");
      check("R1 const hi", exp_rd(0, 1), 16'hFFFF);
      acc(1'b0, 1, 1, 16'h0, "R1 const");
      acc(1'b0, 2, 4, 16'h0, "R1 hold");
      check_irq();

      foreach (VEC[i]) begin
         acc(VEC[i][25], int'(VEC[i][24:23]), int'(VEC[i][22:20]),
             VEC[i][15:0], "R2/R3/R5/R8/R9/R10/R11/R12 table");
         idle(int'(VEC[i][19:16]));
         check_irq();
      end

      // R11 explicit commit while stopped, R10 split read
      acc(1'b1, 2, 0, 16'h0007, "R4");
      acc(1'b1, 2, 3, 16'hDEAD, "R11");
      acc(1'b1, 2, 4, 16'hBEEF, "R11");
      @(negedge clk); b_en = 1; b_we = 0; b_addr = 5'(2 * 8 + 3); #1;
      check("R10 hi", rdata, 16'hDEAD);
      @(negedge clk); b_addr = 5'(2 * 8 + 4); #1;
      check("R10 lo", rdata, 16'hBEEF);
      @(negedge clk); b_en = 0;

      // R11 commit over a reload; R5 with running count and tearing check
      acc(1'b1, 1, 1, 16'h0001, "R9");
      acc(1'b1, 1, 2, 16'h0000, "R9");
      acc(1'b1, 1, 3, 16'h0000, "R11");
      acc(1'b1, 1, 4, 16'h0001, "R11");
      acc(1'b1, 1, 0, 16'h0020, "R3");
      for (int k = 0; k < 40; k++) begin
         acc(1'b0, 1, 3, 16'h0, "R10 running hi");
         acc(1'b0, 1, 4, 16'h0, "R10 running lo");
         check_irq();
      end
      acc(1'b0, 1, 0, 16'h0, "R5 flag");

      // R1 second reset
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      acc(1'b0, 1, 2, 16'h0, "R1 const after reset");
      acc(1'b0, 0, 0, 16'h0, "R1 ctrl after reset");
      check_irq();

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule